// File: doc/BRIEF.md
# Bitfield-Virtualizing Register Bridge

This bridge sits between a simple CPU memory bus and a remote device that keeps its control state in packed 16-bit registers. Software does not see those registers. It sees one bus word per bitfield, called a field variable. A read returns the field alone, zero-extended. A write changes only that field. The bridge holds a local shadow image of every remote register. It merges field writes into that image and pushes whole registers to the device through a serial access engine. The wire protocol of that engine is outside this block.

A write can take one of two paths. A deferred write finishes in one bus clock and marks its register dirty. The dirty registers go out later, when a flush request arrives. A lockstep write holds the bus until the remote write has been acknowledged, so software can rely on the order of its writes. Fields that can be read are fetched from the device on every read. Write-only fields are answered from the shadow image. A 32-bit variable can span two adjacent registers: the low half sits in the lower index and the high half in the next one. The field map is a parameter.

Top module: `reg_field_bridge`

## Requirements
- R1: A read of a readable field variable fetches its remote register and returns the field's bits right-justified, with every bit above the field width zero. Each field map entry is 16 bits: bits 3:0 hold the register index, bits 7:4 the field LSB, bits 13:8 the width (0 means unmapped, 32 means a span over two registers) and bits 15:14 the access type (0 read/write, 1 read-only, 2 write-only).
- R2: A write to a field variable replaces only that field's bits in the shadow image of its register. The other bits keep their values, and the complete 16-bit image is what the bridge transmits.
- R3: A read of a write-only field is answered from the shadow image in the cycle it is presented, with no remote access.
- R4: A deferred write (`cpu_lock` low) completes in the cycle it is presented when the bridge is idle. It causes no remote write until a flush is requested.
- R5: A pulse on `flush` sends every dirty register in ascending index order. A register's dirty mark is cleared only when its remote write is acknowledged, so a second flush with no new writes sends nothing.
- R6: A lockstep write (`cpu_lock` high) sends the affected register or registers at once. `cpu_ready` stays low until the last remote write is acknowledged, and that register is then no longer dirty.
- R7: A 32-bit variable splits on write: bits 15:0 go to its register index and bits 31:16 to the next index. On read it joins the two fetched halves the same way.
- R8: A CPU read is answered within 8 bus clocks of being presented, even when it arrives during a flush. CPU requests take priority over pending flush transfers.
- R9: A write to an unmapped or read-only variable changes nothing and completes at once. A read of an unmapped variable returns zero at once.
- R10: After reset the shadow image and dirty marks are zero, no remote request is active and `cpu_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | CPU access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_lock | input | 1 | 1 = lockstep write, 0 = deferred write |
| cpu_addr | input | AW | Field variable index |
| cpu_wdata | input | 32 | Write data, right-justified |
| cpu_rdata | output | 32 | Read data, valid when cpu_ready |
| cpu_ready | output | 1 | Access completes on this clock |
| flush | input | 1 | Request to send all dirty registers |
| rem_req | output | 1 | Remote access request, held until rem_ack |
| rem_we | output | 1 | 1 = remote write, 0 = remote read |
| rem_idx | output | IW | Remote register index |
| rem_wdata | output | 16 | Full register image for a remote write |
| rem_ack | input | 1 | Remote access done |
| rem_rdata | input | 16 | Remote register content, valid with rem_ack |

## Verification
The hardest case to reach is a read that lands while a flush is already moving registers. That read has to wait for the transfer in flight, then do a two-half fetch, and still meet the 8-clock window. The bench loads four dirty registers, pulses the flush, and waits one extra clock so that a remote write is on the wire before it presents a read of the 32-bit variable. It then checks the wait count, the value returned (the device content as it was before the flush), and that the whole flush still finishes in ascending order. Field packing is swept over 32 value combinations, and each is checked both in the remote image and by reading the fields back.

// File: rtl/reg_field_bridge.sv
module reg_field_bridge #(
  parameter int NREG = 6,
  parameter int NVAR = 8,
  parameter int AW = $clog2(NVAR),
  parameter int READ_WIN = 8,
  parameter logic [NVAR*16-1:0] MAP = 128'h0000_2004_8933_8842_5001_0500_0560_05B0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_sel,
  input  logic          cpu_we,
  input  logic          cpu_lock,
  input  logic [AW-1:0] cpu_addr,
  input  logic [31:0]   cpu_wdata,
  output logic [31:0]   cpu_rdata,
  output logic          cpu_ready,
  input  logic          flush,
  output logic          rem_req,
  output logic          rem_we,
  output logic [$clog2(NREG)-1:0] rem_idx,
  output logic [15:0]   rem_wdata,
  input  logic          rem_ack,
  input  logic [15:0]   rem_rdata
);
  localparam int IW = $clog2(NREG);
  typedef enum logic [1:0] {S_IDLE, S_RD0, S_RD1, S_XFER} state_t;

  state_t          state;
  logic [15:0]     shadow [NREG];
  logic [NREG-1:0] dirty, xmask;
  logic            sync, flush_pend;
  logic [15:0]     rd_lo;

  logic [15:0] ent;
  assign ent = MAP[{cpu_addr, 4'b0000} +: 16];

  logic [IW-1:0] ridx, ridx1, xidx;
  logic [3:0]    lsb;
  logic [5:0]    wid;
  logic [1:0]    acc;
  assign ridx  = ent[IW-1:0];
  assign ridx1 = ridx + IW'(1);
  assign lsb   = ent[7:4];
  assign wid   = ent[13:8];
  assign acc   = ent[15:14];

  logic mapped, wide, wr_ok, fetch;
  assign mapped = wid != 6'd0;
  assign wide   = wid == 6'd32;
  assign wr_ok  = mapped && acc != 2'd1;
  assign fetch  = mapped && acc != 2'd2;

  logic [31:0] ones;
  logic [15:0] fmask;
  assign ones  = (32'd1 << wid) - 32'd1;
  assign fmask = ones[15:0] << lsb;

  logic [NREG-1:0] wbits, xbit;
  assign wbits = (NREG'(1) << ridx) | (wide ? (NREG'(1) << ridx1) : '0);

  always_comb begin
    xidx = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (xmask[i]) xidx = IW'(i);
  end
  assign xbit = NREG'(1) << xidx;

  logic xlast;
  assign xlast = (xmask & ~xbit) == '0;

  logic [15:0] src;
  logic [31:0] value;
  assign src = (state == S_RD0) ? rem_rdata : shadow[ridx];
  always_comb begin
    if (!mapped)   value = '0;
    else if (wide) value = (state == S_RD1) ? {rem_rdata, rd_lo} : {shadow[ridx1], shadow[ridx]};
    else           value = 32'((src & fmask) >> lsb);
  end

  always_comb begin
    case (state)
      S_IDLE:  cpu_ready = cpu_sel && (cpu_we ? !(wr_ok && cpu_lock) : !fetch);
      S_RD0:   cpu_ready = rem_ack && !wide;
      S_RD1:   cpu_ready = rem_ack;
      default: cpu_ready = rem_ack && sync && xlast;
    endcase
  end

  assign cpu_rdata = (cpu_ready && !cpu_we) ? value : '0;
  assign rem_req   = state != S_IDLE;
  assign rem_we    = state == S_XFER;
  assign rem_idx   = (state == S_XFER) ? xidx : (state == S_RD1) ? ridx1 : ridx;
  assign rem_wdata = shadow[xidx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      dirty      <= '0;
      xmask      <= '0;
      sync       <= 1'b0;
      flush_pend <= 1'b0;
      rd_lo      <= '0;
      for (int i = 0; i < NREG; i++) shadow[i] <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (cpu_sel) begin
            if (cpu_we && wr_ok) begin
              for (int i = 0; i < NREG; i++) begin
                if (IW'(i) == ridx)
                  shadow[i] <= (shadow[i] & ~fmask) | ((cpu_wdata[15:0] << lsb) & fmask);
                else if (wide && IW'(i) == ridx1)
                  shadow[i] <= cpu_wdata[31:16];
              end
              dirty <= dirty | wbits;
              if (cpu_lock) begin
                xmask <= wbits;
                sync  <= 1'b1;
                state <= S_XFER;
              end
            end else if (!cpu_we && fetch) begin
              state <= S_RD0;
            end
          end else if (flush_pend) begin
            if (dirty != '0) begin
              xmask <= dirty;
              sync  <= 1'b0;
              state <= S_XFER;
            end else begin
              flush_pend <= 1'b0;
            end
          end
        end
        S_RD0: if (rem_ack) begin
          rd_lo <= rem_rdata;
          state <= wide ? S_RD1 : S_IDLE;
        end
        S_RD1: if (rem_ack) state <= S_IDLE;
        default: if (rem_ack) begin
          dirty <= dirty & ~xbit;
          xmask <= xmask & ~xbit;
          if (!sync || xlast) state <= S_IDLE;
          if (!sync && (dirty & ~xbit) == '0) flush_pend <= 1'b0;
        end
      endcase
      if (flush) flush_pend <= 1'b1;
    end
  end

  logic [7:0] rd_wait;
  always_ff @(posedge clk) begin
    if (!rst_n)                                rd_wait <= '0;
    else if (cpu_sel && !cpu_we && !cpu_ready) rd_wait <= rd_wait + 8'd1;
    else                                       rd_wait <= '0;
  end

  assert_read_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_sel && !cpu_we) |-> rd_wait < 8'(READ_WIN));

  assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_req && !rem_ack) |=> (rem_req && $stable(rem_idx) && $stable(rem_we)));

  assert_dirty_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((~dirty & $past(dirty)) != '0) |-> $past(rem_ack && rem_we));

  assert_flush_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_req && rem_we && !sync) |-> ((dirty & ((NREG'(1) << rem_idx) - NREG'(1))) == '0));

  assert_deferred_fast_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_sel && cpu_we && !cpu_lock && !rem_req) |-> cpu_ready);

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_sel && !cpu_we && !mapped) |-> (cpu_ready && cpu_rdata == 32'd0));
endmodule

// File: tb/reg_field_bridge_test.sv
`timescale 1ns/100ps
module reg_field_bridge_test;
  logic clk = 0, rst_n = 0;
  logic cpu_sel = 0, cpu_we = 0, cpu_lock = 0, flush = 0;
  logic [2:0] cpu_addr = 0;
  logic [31:0] cpu_wdata = 0, cpu_rdata;
  logic cpu_ready, rem_req, rem_we, rem_ack;
  logic [2:0] rem_idx;
  logic [15:0] rem_wdata, rem_rdata;

  always #2.5 clk = ~clk;

  reg_field_bridge uut (.clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
    .cpu_lock(cpu_lock), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .flush(flush), .rem_req(rem_req), .rem_we(rem_we),
    .rem_idx(rem_idx), .rem_wdata(rem_wdata), .rem_ack(rem_ack), .rem_rdata(rem_rdata));

  logic [15:0] rmem [8];
  logic [2:0]  log_idx [256];
  int wr_n, rd_n;
  logic poke = 0;
  logic [2:0] poke_idx = 0;
  logic [15:0] poke_val = 0;
  logic ack_r;
  assign rem_ack = ack_r;
  assign rem_rdata = rmem[rem_idx];

  always @(posedge clk) begin
    if (!rst_n) begin
      ack_r <= 0; wr_n <= 0; rd_n <= 0;
      for (int i = 0; i < 8; i++) rmem[i] <= 0;
    end else begin
      ack_r <= rem_req && !ack_r;
      if (rem_req && ack_r) begin
        if (rem_we) begin
          rmem[rem_idx] <= rem_wdata;
          log_idx[wr_n % 256] <= rem_idx;
          wr_n <= wr_n + 1;
        end else rd_n <= rd_n + 1;
      end
      if (poke) rmem[poke_idx] <= poke_val;
    end
  end

  int tests = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input bit we, input bit lock, input logic [2:0] a,
                        input logic [31:0] wd, output logic [31:0] rd, output int w);
    @(negedge clk);
    cpu_sel = 1; cpu_we = we; cpu_lock = lock; cpu_addr = a; cpu_wdata = wd;
    w = 0;
    #0.5;
    while (!cpu_ready && w < 50) begin
      @(negedge clk); #0.5; w++;
    end
    rd = cpu_rdata;
    @(posedge clk); #0.5;
    cpu_sel = 0; cpu_we = 0; cpu_lock = 0;
  endtask

  task automatic poke_reg(input logic [2:0] i, input logic [15:0] v);
    @(negedge clk); poke = 1; poke_idx = i; poke_val = v;
    @(negedge clk); poke = 0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    repeat (30) @(negedge clk);
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int w, base;
    logic [4:0] a, b, c;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!rem_req && !cpu_ready, "R10 idle after reset", {rem_req, cpu_ready}, 0);
    access(0, 0, 3'd4, 0, rd, w);
    chk(rd == 0 && w == 0, "R10 shadow zero", rd, 0);

    for (int k = 0; k < 32; k++) begin
      a = 5'(k); b = 5'((k * 7) % 32); c = 5'(k) ^ 5'd21;
      base = wr_n;
      access(1, 0, 3'd0, {27'h7FFFFFF, a}, rd, w);
      chk(w == 0, "R4 single cycle write", w, 0);
      access(1, 0, 3'd1, 32'(b), rd, w);
      access(1, 0, 3'd2, 32'(c), rd, w);
      repeat (4) @(negedge clk);
      chk(wr_n == base, "R4 no send before flush", wr_n, base);
      do_flush();
      chk(rmem[0] == {a, b, 1'b0, c}, "R2 packed image", rmem[0], {a, b, 1'b0, c});
      access(0, 0, 3'd0, 0, rd, w);
      chk(rd == 32'(a), "R1 field 15:11", rd, a);
      access(0, 0, 3'd1, 0, rd, w);
      chk(rd == 32'(b), "R1 field 10:6", rd, b);
      access(0, 0, 3'd2, 0, rd, w);
      chk(rd == 32'(c), "R1 field 4:0", rd, c);
    end
    access(1, 0, 3'd1, 0, rd, w);
    do_flush();
    chk(rmem[0] == {a, 5'd0, 1'b0, c}, "R2 others kept", rmem[0], {a, 5'd0, 1'b0, c});

    for (int k = 0; k < 16; k++) begin
      poke_reg(3'd1, 16'(k * 16'h1357));
      access(0, 0, 3'd3, 0, rd, w);
      chk(rd == 32'(16'(k * 16'h1357)), "R1 read-only full word", rd, 16'(k * 16'h1357));
    end
    base = wr_n;
    access(1, 0, 3'd3, 32'h1111, rd, w);
    chk(w == 0, "R9 read-only write immediate", w, 0);
    do_flush();
    chk(wr_n == base && rmem[1] == 16'(15 * 16'h1357), "R9 read-only write ignored", wr_n, base);

    base = rd_n;
    access(1, 0, 3'd4, 32'h1AB, rd, w);
    access(1, 0, 3'd5, 32'h3FF, rd, w);
    access(0, 0, 3'd4, 0, rd, w);
    chk(rd == 32'hAB && w == 0, "R3 write-only 8-bit", rd, 32'hAB);
    access(0, 0, 3'd5, 0, rd, w);
    chk(rd == 32'h1FF && w == 0, "R3 write-only 9-bit", rd, 32'h1FF);
    chk(rd_n == base, "R3 no remote read", rd_n, base);
    do_flush();
    chk(rmem[2] == 16'h0AB0 && rmem[3] == 16'h0FF8, "R2 write-only images", {rmem[2], rmem[3]}, 32'h0AB00FF8);

    base = wr_n;
    access(1, 0, 3'd6, 32'hDEADBEEF, rd, w);
    access(1, 0, 3'd4, 32'h12, rd, w);
    access(1, 0, 3'd0, 32'h3, rd, w);
    do_flush();
    chk(wr_n == base + 4, "R5 all dirty sent", wr_n, base + 4);
    chk(log_idx[base % 256] == 0 && log_idx[(base + 1) % 256] == 2 &&
        log_idx[(base + 2) % 256] == 4 && log_idx[(base + 3) % 256] == 5, "R5 ascending order",
        {log_idx[base % 256], log_idx[(base + 1) % 256], log_idx[(base + 2) % 256], log_idx[(base + 3) % 256]}, 12'o0245);
    chk(rmem[4] == 16'hBEEF && rmem[5] == 16'hDEAD, "R7 split on write", {rmem[5], rmem[4]}, 32'hDEADBEEF);
    do_flush();
    chk(wr_n == base + 4, "R5 dirty cleared", wr_n, base + 4);

    poke_reg(3'd4, 16'h1234);
    poke_reg(3'd5, 16'h5678);
    access(0, 0, 3'd6, 0, rd, w);
    chk(rd == 32'h56781234, "R7 join on read", rd, 32'h56781234);
    chk(w < 8, "R8 wide read window", w, 7);

    base = wr_n;
    access(1, 1, 3'd1, 32'h15, rd, w);
    chk(w >= 1 && wr_n == base + 1, "R6 lockstep waits for ack", wr_n, base + 1);
    chk(rmem[0][10:6] == 5'h15 && log_idx[base % 256] == 0, "R6 lockstep content", rmem[0][10:6], 5'h15);
    access(1, 1, 3'd6, 32'hCAFEF00D, rd, w);
    chk(wr_n == base + 3 && rmem[4] == 16'hF00D && rmem[5] == 16'hCAFE, "R6 R7 lockstep span", wr_n, base + 3);
    do_flush();
    chk(wr_n == base + 3, "R6 no dirty left", wr_n, base + 3);

    base = wr_n;
    access(1, 0, 3'd0, 32'h1F, rd, w);
    access(1, 0, 3'd2, 32'h0A, rd, w);
    access(1, 0, 3'd4, 32'h77, rd, w);
    access(1, 0, 3'd6, 32'h0BADC0DE, rd, w);
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    access(0, 0, 3'd6, 0, rd, w);
    chk(w >= 3 && w < 8, "R8 read during flush window", w, 7);
    chk(rd == 32'hCAFEF00D, "R8 read during flush value", rd, 32'hCAFEF00D);
    repeat (30) @(negedge clk);
    chk(wr_n == base + 4 && rmem[4] == 16'hC0DE && rmem[5] == 16'h0BAD, "R5 flush completes after read", wr_n, base + 4);

    base = wr_n;
    access(1, 0, 3'd7, 32'hFFFF, rd, w);
    chk(w == 0, "R9 unmapped write immediate", w, 0);
    access(0, 0, 3'd7, 0, rd, w);
    chk(rd == 0 && w == 0, "R9 unmapped read zero", rd, 0);
    do_flush();
    chk(wr_n == base, "R9 unmapped write no send", wr_n, base);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule